// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot command register and the slot event register of a hot-plug capable downstream or root port. Software reaches both through a 16-bit register port with byte enables: one select bit picks the command register or the event register, and a read returns the selected one. The port is a plain single-cycle strobe that is always accepted. It has no back-pressure and no ready signal.

Physical activity enters on four single-cycle pulse inputs: device insertion, removal request, attention button press and link state change. The block turns latched events and their enables into a hot-plug interrupt level. A port that uses message signalling gets a one-cycle message request carrying the configured vector number each time that level rises. Otherwise the level is driven onto a legacy interrupt line. The block also drives a power-off indication, a one-cycle detach pulse and a one-cycle busy pulse for hot-plug actions refused while the interlock is engaged.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the command register holds all enables, the global interrupt enable and the interlock control at 0, with the attention indicator (bits 7:6) at 2'b11. With a power controller, the power indicator (bits 9:8) is 2'b01 and power control (bit 10) is 0 if `slot_populated` is high; otherwise they are 2'b11 and 1. The event register is 0 except bit 6 (presence), which equals `slot_populated`.
- R2: A command write (`reg_sel`=0) changes only bits 12:0 in the enabled bytes (`reg_be[0]` = bits 7:0, `reg_be[1]` = bits 15:8). Bits 15:13 read 0. Bit 10 is writable only when a power controller is present.
- R3: Bit 11 of the command register always reads 0. A command write that sets it inverts event bit 7 (interlock engaged).
- R4: Every command write with at least one byte enabled sets event bit 4 (command done), whatever fields it changes.
- R5: In the event register, bits 0 (button), 3 (presence changed), 4 (command done) and 8 (link changed) clear when written as 1 in an enabled byte. Bits 6 and 7 ignore event-register writes.
- R6: The level is true when command bit 5 is set and any event bit 0/3/4/8 is set together with its enable, command bit 0/3/4/12. `irq_o` equals the level while `msi_en` is low and is 0 while it is high.
- R7: With `msi_en` high, `msg_req` pulses for one cycle, with `msg_vec` equal to `msg_num`, in the cycle after the level goes from 0 to 1. An event that is already latched raises no new message.
- R8: `dev_insert` sets event bits 6, 3 and 0. While bit 7 is set it changes nothing and `busy_err` pulses instead.
- R9: `attn_press` sets event bit 0. `dev_remove` sets bit 0 unless bit 7 is set, in which case `busy_err` pulses.
- R10: A command write that leaves bit 10 at 1 and bits 9:8 at 2'b11 while bit 6 is set detaches the slot. Bit 6 clears, bit 3 sets and `detach` pulses. `pwr_off` follows command bit 10.
- R11: When an event pulse and a register write share a cycle, the write takes effect first and the event is applied to its result.
- R12: `link_change` sets event bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_populated | input | 1 | Device present at reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command register, 1 = event register |
| reg_be | input | 2 | Byte enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Selected register contents |
| dev_insert | input | 1 | Device insertion pulse |
| dev_remove | input | 1 | Removal request pulse |
| attn_press | input | 1 | Attention button pulse |
| link_change | input | 1 | Link state change pulse |
| msi_en | input | 1 | Message signalling enabled |
| msg_num | input | VEC_W | Interrupt vector number |
| irq_o | output | 1 | Legacy interrupt level |
| msg_req | output | 1 | One-cycle message request |
| msg_vec | output | VEC_W | Vector carried by the message |
| busy_err | output | 1 | Action refused while interlock engaged |
| detach | output | 1 | One-cycle slot detach pulse |
| pwr_off | output | 1 | Slot power controller off |

## Verification
The bench builds the block with its defaults: a power controller present and a 5-bit vector. The power controller makes power control writable, so the detach path and the populated-dependent reset indicator are both reachable. Random command writes then hit the detach condition and the interlock toggle often, with event pulses landing in the same cycles as writes.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int ST_BTN  = 0;
  localparam int ST_PCHG = 3;
  localparam int ST_DONE = 4;
  localparam int ST_PRES = 6;
  localparam int ST_LOCK = 7;
  localparam int ST_LINK = 8;

  localparam int CT_BTN_EN  = 0;
  localparam int CT_PCHG_EN = 3;
  localparam int CT_DONE_EN = 4;
  localparam int CT_GIE     = 5;
  localparam int CT_ATTN_LO = 6;
  localparam int CT_PWRI_LO = 8;
  localparam int CT_PWR     = 10;
  localparam int CT_LOCKCMD = 11;
  localparam int CT_LINK_EN = 12;

  localparam logic [1:0]  IND_ON    = 2'b01;
  localparam logic [1:0]  IND_OFF   = 2'b11;
  localparam logic [15:0] STA_W1C   = 16'h0119;
  localparam logic [15:0] CTL_WR_PC = 16'h1FFF;
  localparam logic [15:0] CTL_WR_NP = 16'h1BFF;

  typedef struct packed {
    logic ins;
    logic rem;
    logic btn;
    logic lnk;
  } hp_evt_t;

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTRL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        populated,
  input  logic        wr,
  input  logic        sel,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  input  hp_evt_t     evt,
  output logic [15:0] ctrl_q,
  output logic [15:0] sta_q,
  output logic        busy_q,
  output logic        detach_q
);
  localparam logic [15:0] WMASK = HAS_PWR_CTRL ? CTL_WR_PC : CTL_WR_NP;

  logic [1:0]  rst_pwri;
  logic        rst_pwr;
  logic [15:0] ctrl_rst, sta_rst;
  logic [15:0] c_n, s_n, m;
  logic        ctrl_wr, sta_wr, busy_n, det_n;

  generate
    if (HAS_PWR_CTRL) begin : g_pwr
      assign rst_pwri = populated ? IND_ON : IND_OFF;
      assign rst_pwr  = ~populated;
    end else begin : g_nopwr
      assign rst_pwri = IND_OFF;
      assign rst_pwr  = 1'b0;
    end
  endgenerate

  assign ctrl_rst = {5'b0, rst_pwr, rst_pwri, IND_OFF, 6'b0};
  assign sta_rst  = {9'b0, populated, 6'b0};

  always_comb begin
    m       = lane_mask(be) & WMASK;
    ctrl_wr = wr & ~sel & (|be);
    sta_wr  = wr & sel & (|be);
    c_n     = ctrl_q;
    s_n     = sta_q;
    det_n   = 1'b0;
    if (ctrl_wr) begin
      c_n = (ctrl_q & ~m) | (wdata & m);
      if (c_n[CT_LOCKCMD]) s_n[ST_LOCK] = ~s_n[ST_LOCK];
      c_n[CT_LOCKCMD] = 1'b0;
      if (sta_q[ST_PRES] && c_n[CT_PWR] &&
          c_n[CT_PWRI_LO+1:CT_PWRI_LO] == IND_OFF) begin
        s_n[ST_PRES] = 1'b0;
        s_n[ST_PCHG] = 1'b1;
        det_n        = 1'b1;
      end
      s_n[ST_DONE] = 1'b1;
    end
    if (sta_wr) s_n = s_n & ~(wdata & lane_mask(be) & STA_W1C);
    busy_n = (evt.ins | evt.rem) & s_n[ST_LOCK];
    if (evt.ins && !s_n[ST_LOCK]) begin
      s_n[ST_PRES] = 1'b1;
      s_n[ST_PCHG] = 1'b1;
      s_n[ST_BTN]  = 1'b1;
    end
    if (evt.rem && !s_n[ST_LOCK]) s_n[ST_BTN] = 1'b1;
    if (evt.btn) s_n[ST_BTN] = 1'b1;
    if (evt.lnk) s_n[ST_LINK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= ctrl_rst;
      sta_q    <= sta_rst;
      busy_q   <= 1'b0;
      detach_q <= 1'b0;
    end else begin
      ctrl_q   <= c_n;
      sta_q    <= s_n;
      busy_q   <= busy_n;
      detach_q <= det_n;
    end
  end
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify #(
  parameter int N_EV  = 4,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EV-1:0]  ev_src,
  input  logic [N_EV-1:0]  ev_en,
  input  logic             gie,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] msg_num,
  output logic             irq_o,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec
);
  logic level, lvl_prev;

  assign level   = gie & (|(ev_src & ev_en));
  assign irq_o   = level & ~msi_en;
  assign msg_req = msi_en & level & ~lvl_prev;
  assign msg_vec = msg_num;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= level;
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W        = 5,
  parameter bit HAS_PWR_CTRL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_populated,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [1:0]       reg_be,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             dev_insert,
  input  logic             dev_remove,
  input  logic             attn_press,
  input  logic             link_change,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] msg_num,
  output logic             irq_o,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec,
  output logic             busy_err,
  output logic             detach,
  output logic             pwr_off
);
  localparam int N_EV = 4;

  logic [15:0] ctrl_q, sta_q;
  hp_evt_t     evt;
  logic [N_EV-1:0] ev_src, ev_en;

  assign evt = '{ins: dev_insert, rem: dev_remove, btn: attn_press, lnk: link_change};

  hp_slot_regs #(.HAS_PWR_CTRL(HAS_PWR_CTRL)) u_regs (
    .clk(clk), .rst_n(rst_n), .populated(slot_populated),
    .wr(reg_wr), .sel(reg_sel), .be(reg_be), .wdata(reg_wdata), .evt(evt),
    .ctrl_q(ctrl_q), .sta_q(sta_q), .busy_q(busy_err), .detach_q(detach)
  );

  assign ev_src = {sta_q[ST_LINK], sta_q[ST_DONE], sta_q[ST_PCHG], sta_q[ST_BTN]};
  assign ev_en  = {ctrl_q[CT_LINK_EN], ctrl_q[CT_DONE_EN], ctrl_q[CT_PCHG_EN], ctrl_q[CT_BTN_EN]};

  hp_slot_notify #(.N_EV(N_EV), .VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst_n(rst_n), .ev_src(ev_src), .ev_en(ev_en),
    .gie(ctrl_q[CT_GIE]), .msi_en(msi_en), .msg_num(msg_num),
    .irq_o(irq_o), .msg_req(msg_req), .msg_vec(msg_vec)
  );

  assign reg_rdata = reg_sel ? sta_q : ctrl_q;
  assign pwr_off   = ctrl_q[CT_PWR];
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [1:0]  reg_be,
  input logic [15:0] reg_wdata,
  input logic        dev_insert,
  input logic        msi_en,
  input logic        irq_o,
  input logic        msg_req,
  input logic        busy_err,
  input logic [15:0] ctrl_q,
  input logic [15:0] sta_q
);
  // R4
  cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_be != 2'b00) |=> sta_q[4]);

  // R5
  done_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_be[0] && reg_wdata[4]) |=> !sta_q[4]);

  // R5
  pres_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !dev_insert) |=> $stable(sta_q[6]));

  // R6
  legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !irq_o);

  // R7
  msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |=> !msg_req);

  // R7
  msg_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (msi_en && ctrl_q[5]));

  // R8
  busy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> sta_q[7]);
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_be(reg_be), .reg_wdata(reg_wdata), .dev_insert(dev_insert),
  .msi_en(msi_en), .irq_o(irq_o), .msg_req(msg_req), .busy_err(busy_err),
  .ctrl_q(ctrl_q), .sta_q(sta_q)
);

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;
  localparam int VEC_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_populated = 1'b1;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [1:0] reg_be = 2'b00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic dev_insert = 1'b0, dev_remove = 1'b0, attn_press = 1'b0, link_change = 1'b0;
  logic msi_en = 1'b1;
  logic [VEC_W-1:0] msg_num = 5'd13;
  logic irq_o, msg_req, busy_err, detach, pwr_off;
  logic [VEC_W-1:0] msg_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] e_ctrl, e_sta;
  logic e_busy, e_det, e_msg;

  always #10 clk = ~clk;

  hp_slot_ctrl #(.VEC_W(VEC_W), .HAS_PWR_CTRL(1'b1)) u_hp_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_populated(slot_populated),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dev_insert(dev_insert), .dev_remove(dev_remove),
    .attn_press(attn_press), .link_change(link_change), .msi_en(msi_en),
    .msg_num(msg_num), .irq_o(irq_o), .msg_req(msg_req), .msg_vec(msg_vec),
    .busy_err(busy_err), .detach(detach), .pwr_off(pwr_off)
  );

  function automatic logic lvl(input logic [15:0] c, input logic [15:0] s);
    return c[5] & ((s[0] & c[0]) | (s[3] & c[3]) | (s[4] & c[4]) | (s[8] & c[12]));
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic wr, input logic sel, input logic [1:0] be, input logic [15:0] wd,
                       input logic ins, input logic rem, input logic btn, input logic lnk);
    logic [15:0] m, c, s;
    logic old_l;
    m = {{8{be[1]}}, {8{be[0]}}};
    c = e_ctrl;
    s = e_sta;
    e_det = 1'b0;
    if (wr && !sel && be != 2'b00) begin
      c = (c & ~(m & 16'h1FFF)) | (wd & m & 16'h1FFF);
      if (c[11]) s[7] = ~s[7];
      c[11] = 1'b0;
      if (e_sta[6] && c[10] && c[9:8] == 2'b11) begin
        s[6] = 1'b0; s[3] = 1'b1; e_det = 1'b1;
      end
      s[4] = 1'b1;
    end
    if (wr && sel && be != 2'b00) s = s & ~(wd & m & 16'h0119);
    e_busy = (ins | rem) & s[7];
    if (ins && !s[7]) s = s | 16'h0049;
    if (rem && !s[7]) s[0] = 1'b1;
    if (btn) s[0] = 1'b1;
    if (lnk) s[8] = 1'b1;
    old_l  = lvl(e_ctrl, e_sta);
    e_ctrl = c;
    e_sta  = s;
    e_msg  = msi_en & lvl(c, s) & ~old_l;
  endtask

  task automatic compare(input string tag);
    reg_sel = 1'b0; #1;
    chk(tag, "ctrl", reg_rdata, e_ctrl);
    reg_sel = 1'b1; #1;
    chk(tag, "status", reg_rdata, e_sta);
    chk(tag, "irq", {15'b0, irq_o}, {15'b0, lvl(e_ctrl, e_sta) & ~msi_en});
    chk(tag, "msg", {15'b0, msg_req}, {15'b0, e_msg});
    if (e_msg) chk(tag, "vector", {11'b0, msg_vec}, {11'b0, msg_num});
    chk(tag, "busy", {15'b0, busy_err}, {15'b0, e_busy});
    chk(tag, "detach", {15'b0, detach}, {15'b0, e_det});
    chk(tag, "pwr_off", {15'b0, pwr_off}, {15'b0, e_ctrl[10]});
  endtask

  task automatic step(input string tag, input logic wr, input logic sel, input logic [1:0] be,
                      input logic [15:0] wd, input logic ins, input logic rem,
                      input logic btn, input logic lnk);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_be = be; reg_wdata = wd;
    dev_insert = ins; dev_remove = rem; attn_press = btn; link_change = lnk;
    model(wr, sel, be, wd, ins, rem, btn, lnk);
    @(posedge clk);
    #2;
    reg_wr = 1'b0; dev_insert = 1'b0; dev_remove = 1'b0; attn_press = 1'b0; link_change = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    e_ctrl = 16'h01C0; e_sta = 16'h0040; e_busy = 0; e_det = 0; e_msg = 0;
    #2;
    compare("R1");

    // command write with done enable: level rises -> message
    step("R4", 1, 0, 2'b11, 16'h0030, 0, 0, 0, 0);
    step("R7", 1, 0, 2'b11, 16'h0030, 0, 0, 0, 0);
    step("R5", 1, 1, 2'b11, 16'h0010, 0, 0, 0, 0);
    step("R5", 1, 1, 2'b11, 16'h00C0, 0, 0, 0, 0);
    // interlock toggle, then refused insertion and removal
    step("R3", 1, 0, 2'b11, 16'h0801, 0, 0, 0, 0);
    step("R8", 0, 0, 2'b00, 16'h0000, 1, 0, 0, 0);
    step("R9", 0, 0, 2'b00, 16'h0000, 0, 1, 0, 0);
    step("R3", 1, 0, 2'b11, 16'h0801, 0, 0, 0, 0);
    step("R5", 1, 1, 2'b11, 16'hFFFF, 0, 0, 0, 0);
    step("R8", 0, 0, 2'b00, 16'h0000, 1, 0, 0, 0);
    step("R9", 0, 0, 2'b00, 16'h0000, 0, 0, 1, 0);
    step("R12", 0, 0, 2'b00, 16'h0000, 0, 0, 0, 1);
    step("R6", 1, 1, 2'b11, 16'h0119, 0, 0, 0, 0);
    msi_en = 1'b0;
    step("R6", 1, 0, 2'b11, 16'h1029, 0, 0, 0, 1);
    step("R6", 1, 1, 2'b11, 16'h0100, 0, 0, 0, 0);
    msi_en = 1'b1;
    // byte enables
    step("R2", 1, 0, 2'b01, 16'hFFFF, 0, 0, 0, 0);
    step("R2", 1, 0, 2'b10, 16'hE2FF, 0, 0, 0, 0);
    // detach: power off, indicator off, device present
    step("R8", 0, 0, 2'b00, 16'h0000, 1, 0, 0, 0);
    step("R10", 1, 0, 2'b11, 16'h07F0, 0, 0, 0, 0);
    // same-cycle ordering: interlock engaged by the write, insertion refused
    step("R11", 1, 0, 2'b11, 16'h0800, 1, 0, 0, 0);
    step("R11", 1, 1, 2'b11, 16'h0119, 0, 0, 1, 0);
    step("R11", 1, 0, 2'b11, 16'h0800, 0, 1, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:28] == 4'h0) msi_en = ~msi_en;
      step("R6", r[0], r[1], r[3:2], r[19:4] | {r[20], 15'b0},
           r[24:21] == 4'h0, r[27:25] == 3'h0, r[29:28] == 2'h0, r[30] & r[31]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule